// File: doc/BRIEF.md
# ADC Power-State Sequencer

This block sits on the host side of an external parallel sampling converter. It moves the converter between three power states: full operation, a light nap that wakes quickly, and a deep sleep that also powers down the reference. It drives the converter's active-low shutdown line and its chip-select line, and it changes them only in a safe order. Three events are timed: chip-select is settled before every shutdown edge, the converter is given its short wake-up time after a nap, and it is given its long wake-up time after a sleep. All three counts are taken in system clock cycles, and each is derived from a nanosecond parameter and rounded up.

A request port takes nap, sleep and wake commands. The level of chip-select at the moment shutdown is asserted selects the mode: low gives nap and high gives sleep. A `ready` flag shows when the converter may again be told to convert. A companion conversion controller sends its start requests through the block, and the block passes them on only while `ready` is high. A command to power down that arrives while a conversion is running is held until the converter reports that it is idle.

Top module: `adc_pwr_seq`

## Requirements
- R1: After synchronous reset the block is in the active state: `shdn_n`=1, `cs_n`=0 and `ready`=1.
- R2: A nap command (`cmd_code`=2'b01 with `cmd_valid`=1) received in the active state holds `shdn_n`=1 with `cs_n`=0 for SETUP cycles. It then drives `shdn_n`=0 with `cs_n`=0 and holds that until a wake command arrives.
- R3: Before any edge of `shdn_n`, `cs_n` keeps its level for SETUP cycles, where SETUP = ceil(CS_SETUP_NS*CLK_HZ/1e9), and at least 1.
- R4: A wake command (`cmd_code`=2'b11) received in nap sets `shdn_n`=1 with `cs_n`=0. `ready` stays low for exactly NAPW = ceil(NAP_WAKE_NS*CLK_HZ/1e9) cycles and then rises.
- R5: A sleep command (`cmd_code`=2'b10) received in the active state holds `shdn_n`=1 with `cs_n`=1 for SETUP cycles. It then drives `shdn_n`=0 with `cs_n`=1.
- R6: A wake command received in sleep sets `shdn_n`=1 with `cs_n`=1. `ready` stays low for exactly SLPW = ceil(SLEEP_WAKE_NS*CLK_HZ/1e9) cycles and then rises.
- R7: A nap or sleep command received in the active state while `busy_n`=0 is held. The state does not change while `busy_n` stays low, and the transition starts on the first clock at which `busy_n` is sampled high.
- R8: `ready` is high only in the active state. A wake command received in the active state has no effect.
- R9: `conv_req_out` equals `conv_req_in` only while `ready`=1 and no power-down command is held. Otherwise it is 0.
- R10: A sleep command received in nap first sets `shdn_n`=1 with `cs_n`=0 for SETUP cycles. It then drives `cs_n`=1 for SETUP cycles, and finally drives `shdn_n`=0 with `cs_n`=1.
- R11: Commands have no effect in these cases: nap in nap, nap or sleep in sleep, and any command while a transition or wake-up is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 2 | 01 nap, 10 sleep, 11 wake, 00 none |
| busy_n | input | 1 | Converter status, low while a conversion runs |
| conv_req_in | input | 1 | Conversion start request from the companion controller |
| shdn_n | output | 1 | Converter shutdown line, active low |
| cs_n | output | 1 | Converter chip-select, active low |
| ready | output | 1 | Converter may accept a conversion start |
| conv_req_out | output | 1 | Gated conversion start request to the converter |

## Verification
The bench goes after the rounding of each timing count. A design that truncated instead of rounding up would release `ready` one cycle early after a nap. It also checks the move from nap to sleep. A design that raised chip-select on the same cycle it released shutdown would break the setup rule, and one that skipped the release would leave the converter napping with the wrong mode latched. It holds `busy_n` low under a sleep command. A design that did not defer would cut a conversion short, and one that did not gate requests while the command is held would let a new conversion start. Finally it sends commands that must be ignored: wake while active, repeat commands, and a nap in the middle of a wake-up. A design that obeyed any of them would show an early `ready` or a wrong line level.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_NAP   = 2'b01,
        CMD_SLEEP = 2'b10,
        CMD_WAKE  = 2'b11
    } pwr_cmd_e;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_ENTER_NAP,
        ST_NAP,
        ST_ENTER_SLEEP,
        ST_SLEEP,
        ST_WAKING
    } pwr_state_e;

    // step: in ST_ENTER_SLEEP, 0 = releasing shutdown, 1 = chip-select high
    // deep: the low-power mode being entered or left is sleep
    typedef struct packed {
        pwr_state_e st;
        logic       step;
        logic       deep;
    } seq_t;

    localparam seq_t SEQ_IDLE = '{st: ST_ACTIVE, step: 1'b0, deep: 1'b0};

    // Round a nanosecond interval up to whole clock cycles, never below one.
    function automatic longint unsigned ns_to_cyc(longint unsigned ns,
                                                  longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned max3(longint unsigned a,
                                             longint unsigned b,
                                             longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_defer.sv
module adc_pwr_defer
    import adc_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       in_active,
    input  logic       busy_n,
    output logic       go_valid,
    output logic       go_deep,
    output logic       held
);
    pwr_cmd_e code;
    logic     cmd_down;
    logic     hold_q;
    logic     hold_deep_q;

    assign code     = pwr_cmd_e'(cmd_code);
    assign cmd_down = cmd_valid && (code == CMD_NAP || code == CMD_SLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= 1'b0;
            hold_deep_q <= 1'b0;
        end else if (!in_active || busy_n) begin
            hold_q      <= 1'b0;
        end else if (cmd_down) begin
            hold_q      <= 1'b1;
            hold_deep_q <= (code == CMD_SLEEP);
        end
    end

    assign go_valid = in_active && busy_n && (cmd_down || hold_q);
    assign go_deep  = cmd_down ? (code == CMD_SLEEP) : hold_deep_q;
    assign held     = hold_q;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 100_000_000,
    parameter longint unsigned CS_SETUP_NS   = 10,
    parameter longint unsigned NAP_WAKE_NS   = 400,
    parameter longint unsigned SLEEP_WAKE_NS = 20_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       busy_n,
    input  logic       conv_req_in,
    output logic       shdn_n,
    output logic       cs_n,
    output logic       ready,
    output logic       conv_req_out
);
    localparam longint unsigned SETUP_CYC = ns_to_cyc(CS_SETUP_NS, CLK_HZ);
    localparam longint unsigned NAP_CYC   = ns_to_cyc(NAP_WAKE_NS, CLK_HZ);
    localparam longint unsigned SLEEP_CYC = ns_to_cyc(SLEEP_WAKE_NS, CLK_HZ);
    localparam longint unsigned MAX_CYC   = max3(SETUP_CYC, NAP_CYC, SLEEP_CYC);
    localparam int              CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_NAP   = CNT_W'(NAP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SLEEP = CNT_W'(SLEEP_CYC - 1);

    seq_t             cur_q, nxt;
    pwr_cmd_e         code;
    logic             wake_cmd, sleep_cmd;
    logic             go_valid, go_deep, held;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    assign code      = pwr_cmd_e'(cmd_code);
    assign wake_cmd  = cmd_valid && (code == CMD_WAKE);
    assign sleep_cmd = cmd_valid && (code == CMD_SLEEP);

    adc_pwr_defer u_defer (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .in_active (cur_q.st == ST_ACTIVE),
        .busy_n    (busy_n),
        .go_valid  (go_valid),
        .go_deep   (go_deep),
        .held      (held)
    );

    always_comb begin
        nxt = cur_q;
        unique case (cur_q.st)
            ST_ACTIVE: begin
                if (go_valid) begin
                    nxt = go_deep ? '{st: ST_ENTER_SLEEP, step: 1'b1, deep: 1'b1}
                                  : '{st: ST_ENTER_NAP,   step: 1'b0, deep: 1'b0};
                end
            end
            ST_ENTER_NAP: begin
                if (tmr_done) nxt = '{st: ST_NAP, step: 1'b0, deep: 1'b0};
            end
            ST_NAP: begin
                if (wake_cmd)
                    nxt = '{st: ST_WAKING, step: 1'b0, deep: 1'b0};
                else if (sleep_cmd)
                    nxt = '{st: ST_ENTER_SLEEP, step: 1'b0, deep: 1'b1};
            end
            ST_ENTER_SLEEP: begin
                if (tmr_done) begin
                    nxt = cur_q.step ? '{st: ST_SLEEP,       step: 1'b1, deep: 1'b1}
                                     : '{st: ST_ENTER_SLEEP, step: 1'b1, deep: 1'b1};
                end
            end
            ST_SLEEP: begin
                if (wake_cmd) nxt = '{st: ST_WAKING, step: 1'b0, deep: 1'b1};
            end
            ST_WAKING: begin
                if (tmr_done) nxt = SEQ_IDLE;
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (nxt != cur_q);
        unique case (nxt.st)
            ST_ENTER_NAP, ST_ENTER_SLEEP: tmr_val = LD_SETUP;
            ST_WAKING:                    tmr_val = nxt.deep ? LD_SLEEP : LD_NAP;
            default:                      tmr_val = '0;
        endcase
    end

    adc_pwr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= SEQ_IDLE;
        else     cur_q <= nxt;
    end

    always_comb begin
        unique case (cur_q.st)
            ST_ENTER_SLEEP: cs_n = cur_q.step;
            ST_SLEEP:       cs_n = 1'b1;
            ST_WAKING:      cs_n = cur_q.deep;
            default:        cs_n = 1'b0;
        endcase
    end

    assign shdn_n       = !(cur_q.st == ST_NAP || cur_q.st == ST_SLEEP);
    assign ready        = (cur_q.st == ST_ACTIVE);
    assign conv_req_out = ready && conv_req_in && !held;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk
    import adc_pwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 100_000_000,
    parameter longint unsigned CS_SETUP_NS   = 10,
    parameter longint unsigned NAP_WAKE_NS   = 400,
    parameter longint unsigned SLEEP_WAKE_NS = 20_000_000
) (
    input logic clk,
    input logic rst,
    input logic busy_n,
    input logic conv_req_out,
    input logic shdn_n,
    input logic cs_n,
    input logic ready
);
    localparam longint unsigned SETUP_CYC = ns_to_cyc(CS_SETUP_NS, CLK_HZ);
    localparam longint unsigned NAP_CYC   = ns_to_cyc(NAP_WAKE_NS, CLK_HZ);
    localparam longint unsigned SLEEP_CYC = ns_to_cyc(SLEEP_WAKE_NS, CLK_HZ);

    longint unsigned wake_cnt;
    longint unsigned cs_age;
    logic            cs_prev;
    logic            deep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_cnt <= 0;
            cs_age   <= 0;
            cs_prev  <= 1'b0;
            deep_q   <= 1'b0;
        end else begin
            if (!shdn_n || ready)           wake_cnt <= 0;
            else if (wake_cnt != '1)        wake_cnt <= wake_cnt + 1;
            cs_prev <= cs_n;
            if (cs_n != cs_prev)            cs_age <= 0;
            else if (cs_age != '1)          cs_age <= cs_age + 1;
            if (!shdn_n)                    deep_q <= cs_n;
        end
    end

    a_r3_cs_settled: assert property (@(posedge clk) disable iff (rst)
        ($fell(shdn_n) || $rose(shdn_n)) |-> ($stable(cs_n) && cs_age + 1 >= SETUP_CYC));

    a_r4_nap_wake_time: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (wake_cnt >= NAP_CYC));

    a_r6_sleep_wake_time: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && deep_q) |-> (wake_cnt >= SLEEP_CYC));

    a_r7_leave_when_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(busy_n));

    a_r8_ready_live_lines: assert property (@(posedge clk) disable iff (rst)
        ready |-> (shdn_n && !cs_n));

    a_r9_start_gated: assert property (@(posedge clk) disable iff (rst)
        conv_req_out |-> ready);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
    .CLK_HZ        (CLK_HZ),
    .CS_SETUP_NS   (CS_SETUP_NS),
    .NAP_WAKE_NS   (NAP_WAKE_NS),
    .SLEEP_WAKE_NS (SLEEP_WAKE_NS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_n       (busy_n),
    .conv_req_out (conv_req_out),
    .shdn_n       (shdn_n),
    .cs_n         (cs_n),
    .ready        (ready)
);

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;
    localparam int              PERIOD   = 10;
    localparam longint unsigned T_HZ     = 33_000_000;
    localparam longint unsigned T_SETUP  = 100;
    localparam longint unsigned T_NAP    = 400;
    localparam longint unsigned T_SLEEP  = 3000;

    // Expected counts, rounded up (R3, R4, R6)
    localparam int E_SETUP = int'((T_SETUP * T_HZ + 999_999_999) / 1_000_000_000); // 4
    localparam int E_NAPW  = int'((T_NAP   * T_HZ + 999_999_999) / 1_000_000_000); // 14
    localparam int E_SLPW  = int'((T_SLEEP * T_HZ + 999_999_999) / 1_000_000_000); // 99

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'b00;
    logic       busy_n = 1'b1;
    logic       conv_req_in = 1'b1;
    logic       shdn_n, cs_n, ready, conv_req_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    adc_pwr_seq #(
        .CLK_HZ        (T_HZ),
        .CS_SETUP_NS   (T_SETUP),
        .NAP_WAKE_NS   (T_NAP),
        .SLEEP_WAKE_NS (T_SLEEP)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .busy_n       (busy_n),
        .conv_req_in  (conv_req_in),
        .shdn_n       (shdn_n),
        .cs_n         (cs_n),
        .ready        (ready),
        .conv_req_out (conv_req_out)
    );

    // One check over n cycles: {shdn_n, cs_n, ready, conv_req_out} must equal exp.
    task automatic hold(input string tag, input logic [3:0] exp, input int n);
        logic [3:0] got;
        logic [3:0] first_bad;
        bit         err;
        err = 1'b0;
        first_bad = 4'b0;
        for (int i = 0; i < n; i++) begin
            got = {shdn_n, cs_n, ready, conv_req_out};
            if (got !== exp && !err) begin
                err = 1'b1;
                first_bad = got;
            end
            @(negedge clk);
        end
        total++;
        if (err) begin
            bad++;
            $display("FAIL %s: lines got=%b expected=%b", tag, first_bad, exp);
        end
    endtask

    task automatic send(input logic [1:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hold("R1 reset state", 4'b1011, 1);

        send(2'b11);
        hold("R8 wake while active ignored", 4'b1011, 5);

        send(2'b01);
        hold("R2 nap entry setup", 4'b1000, E_SETUP);
        hold("R2 nap held, R9 start blocked", 4'b0000, 3);
        send(2'b01);
        hold("R11 nap in nap ignored", 4'b0000, 4);
        send(2'b11);
        hold("R4 nap wake window", 4'b1000, E_NAPW);
        hold("R4 ready after nap wake", 4'b1011, 2);

        send(2'b10);
        hold("R5 sleep entry setup", 4'b1100, E_SETUP);
        hold("R5 sleep held", 4'b0100, 3);
        send(2'b01);
        hold("R11 nap in sleep ignored", 4'b0100, 3);
        send(2'b10);
        hold("R11 sleep in sleep ignored", 4'b0100, 3);
        send(2'b11);
        hold("R6 sleep wake window", 4'b1100, E_SLPW);
        hold("R6 ready after sleep wake", 4'b1011, 2);

        send(2'b01);
        hold("R2 nap entry again", 4'b1000, E_SETUP);
        hold("R2 nap again", 4'b0000, 2);
        send(2'b10);
        hold("R10 release from nap", 4'b1000, E_SETUP);
        hold("R10 chip-select raised", 4'b1100, E_SETUP);
        hold("R10 now asleep", 4'b0100, 3);

        send(2'b11);
        hold("R6 wake part one", 4'b1100, 5);
        send(2'b01);
        hold("R11 nap during wake ignored", 4'b1100, E_SLPW - 6);
        hold("R11 ready after wake", 4'b1011, 2);

        busy_n = 1'b0;
        @(negedge clk);
        send(2'b10);
        hold("R7 sleep held while busy, R9 gated", 4'b1010, 6);
        busy_n = 1'b1;
        hold("R7 idle seen at next edge", 4'b1010, 1);
        hold("R7 deferred sleep entry", 4'b1100, E_SETUP);
        hold("R7 asleep after defer", 4'b0100, 2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule